// File: doc/BRIEF.md
# Interrupt Event Log and Source Decoder

The block gathers interrupt events from the device hardware and from four terminal functions: the bus controller, the monitor, and two remote terminals. Each event pulse carries an identifier word. The block holds each event in a latch for its source. It then writes one record per cycle into a 64-word circular log memory. A record takes two words, so the log always holds the 32 most recent events.

A hardware counter keeps the number of events logged since the host last serviced the log. The host interrupt line stays high while that count is nonzero. A pending-source register lets the host find the source of an interrupt quickly. Its low bits flag which terminal classes have raised events. Its upper bits hold the individual hardware causes.

The host works through three signals. It pulses a service strobe after it has drained the log. It reads the pending register and the count through a small register read port. It clears the hardware cause bits by reading the pending register.

Top module: `irq_log_top`

## Requirements
- R1: After reset, the count is 0, the interrupt line is low, the pending register is 0, no log write is issued, and the first record goes to word address 0.
- R2: An event pulse that is accepted in a cycle is written in the next cycle, as long as no higher-priority event is waiting. The write presents two words. Word 0 is {id[12:0], src[2:0]}, with source codes hardware=0, bus controller=1, monitor=2, remote terminal 1=3 and remote terminal 2=4. Word 1 is the event count that includes this event.
- R3: The k-th record since reset (k starting at 0) goes to word address (2*k) mod 64. After 32 records the oldest record is overwritten. The service strobe does not move the write address.
- R4: Events that wait at the same time are written one per cycle, in fixed order: hardware, bus controller, monitor, remote terminal 1, remote terminal 2.
- R5: A pulse is discarded when its source still has an unwritten event that is not being written in that cycle. The waiting event keeps its original identifier. A source whose event is being written in a cycle may accept a new pulse in that same cycle.
- R6: The count rises by one for each record written. At 65535 it saturates and does not wrap.
- R7: The service strobe clears the count. If a record is written in the same cycle as the strobe, the count becomes 1 and word 1 of that record is 1.
- R8: The interrupt output is high exactly when the count is nonzero.
- R9: The pending register bits are set when an event pulse arrives: bit 0 for the bus controller, bit 1 for the monitor, and bit 2 for either remote terminal. The service strobe clears these bits. A set in the same cycle wins over the clear.
- R10: The hardware cause vector of a hardware event is ORed into pending bits [10:3]. A register read returns its data one cycle after the read request. Address 0 returns the pending register. Address 1 returns the count. A read at address 0 returns the value before the clear, then clears the cause bits; a new cause in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_evt_i | input | 1 | Hardware event pulse |
| hw_cause_i | input | 8 | Hardware cause bits for the event |
| hw_id_i | input | 13 | Hardware event identifier |
| term_evt_i | input | 4 | Terminal event pulses: bc, monitor, rt1, rt2 |
| term_id_i | input | 52 | Terminal identifiers, 13 bits each, terminal k at [13k+:13] |
| srv_i | input | 1 | Host service strobe |
| reg_rd_i | input | 1 | Register read request |
| reg_addr_i | input | 1 | Register address: 0 pending, 1 count |
| log_we_o | output | 1 | Log record write enable |
| log_addr_o | output | 6 | Word address of word 0 of the record |
| log_word0_o | output | 16 | Record word 0 (identifier and source code) |
| log_word1_o | output | 16 | Record word 1 (count at logging) |
| evt_cnt_o | output | 16 | Events since last service |
| irq_o | output | 1 | Host interrupt line |
| pend_o | output | 11 | Pending-source register |
| reg_rdata_o | output | 16 | Register read data |

## Verification
The log path is tried in four ways: a lone event, all five sources firing in one cycle, a repeat pulse on a source that is still waiting, and a long train of back-to-back events. Together these separate correct priority order, correct record contents and drop behaviour from reordering, lost events and duplicated events. A train of forty events shows that the write address wraps and that the service strobe does not move it. A train of more than 65535 events shows that the count saturates instead of wrapping. A service strobe given in the same cycle as a write, and reads of both registers, show which of two competing updates wins.

// File: rtl/irq_log_pkg.sv
package irq_log_pkg;
  localparam int NUM_SRC = 5;
  localparam int WORD_W  = 16;
  localparam int CODE_W  = 3;
  typedef enum logic [CODE_W-1:0] {
    SRC_HW  = 3'd0,
    SRC_BC  = 3'd1,
    SRC_MON = 3'd2,
    SRC_RT1 = 3'd3,
    SRC_RT2 = 3'd4
  } src_e;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
  parameter int ID_W = 13
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            evt_i,
  input  logic [ID_W-1:0] id_i,
  input  logic            grant_i,
  output logic            full_o,
  output logic [ID_W-1:0] id_o
);
  logic            full_q;
  logic [ID_W-1:0] id_q;
  logic            take;

  assign take = evt_i && (!full_q || grant_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      id_q   <= '0;
    end else if (take) begin
      full_q <= 1'b1;
      id_q   <= id_i;
    end else if (grant_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign id_o   = id_q;

  // R5
  held_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !grant_i) |=> (full_q && $stable(id_q)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N = 5,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic found;

  // lowest index has highest priority
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        found      = 1'b1;
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
      end
    end
  end

  assign any_o = found;

  // R4
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && ((grant_o & ~req_i) == '0));
  // R4
  grant_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |-> grant_o[0]);
endmodule

// File: rtl/irq_log_ctrl.sv
module irq_log_ctrl #(
  parameter int LOG_WORDS = 64,
  parameter int CNT_W     = 16,
  localparam int ADDR_W   = $clog2(LOG_WORDS),
  localparam int ENT_W    = ADDR_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              srv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cnt_next_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ENT_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_inc, cnt_d;

  assign cnt_base = srv_i ? '0 : cnt_q;
  assign cnt_inc  = (cnt_base == CNT_MAX) ? CNT_MAX : cnt_base + 1'b1;
  assign cnt_d    = we_i ? cnt_inc : cnt_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (we_i) ptr_q <= ptr_q + 1'b1;
    end
  end

  assign addr_o     = {ptr_q, 1'b0};
  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_inc;

  // R3
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (addr_o == ADDR_W'($past(addr_o) + 2)));
  // R3
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(addr_o));
  // R6
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !srv_i) |=> (cnt_q == CNT_MAX));
  // R7
  srv_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srv_i && !we_i) |=> (cnt_q == '0));
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int HW_W   = 8,
  parameter int CNT_W  = 16,
  parameter int WORD_W = 16,
  localparam int PEND_W = 3 + HW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_evt_i,
  input  logic [HW_W-1:0]   hw_cause_i,
  input  logic [3:0]        term_evt_i,
  input  logic              srv_i,
  input  logic              rd_i,
  input  logic              addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [PEND_W-1:0] pend_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic [2:0]        term_q, term_set;
  logic [HW_W-1:0]   hw_q, hw_set;
  logic [PEND_W-1:0] pend;
  logic              hw_clr;
  logic [WORD_W+PEND_W-1:0] pend_ext;
  logic [WORD_W+CNT_W-1:0]  cnt_ext;

  // rt1 and rt2 share bit 2
  assign term_set = {term_evt_i[3] | term_evt_i[2], term_evt_i[1], term_evt_i[0]};
  assign hw_set   = hw_evt_i ? hw_cause_i : '0;
  assign hw_clr   = rd_i && !addr_i;
  assign pend     = {hw_q, term_q};
  assign pend_ext = {{WORD_W{1'b0}}, pend};
  assign cnt_ext  = {{WORD_W{1'b0}}, cnt_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      term_q  <= '0;
      hw_q    <= '0;
      rdata_o <= '0;
    end else begin
      term_q <= (srv_i ? 3'b000 : term_q) | term_set;
      hw_q   <= (hw_clr ? '0 : hw_q) | hw_set;
      if (rd_i) rdata_o <= addr_i ? cnt_ext[WORD_W-1:0] : pend_ext[WORD_W-1:0];
    end
  end

  assign pend_o = pend;

  // R10
  hw_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_clr && !hw_evt_i) |=> (pend_o[PEND_W-1:3] == '0));
  // R9
  term_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srv_i && term_evt_i == 4'b0) |=> (pend_o[2:0] == 3'b000));
endmodule

// File: rtl/irq_log_top.sv
module irq_log_top
  import irq_log_pkg::*;
#(
  parameter int NUM_TERM  = 4,
  parameter int HW_W      = 8,
  parameter int LOG_WORDS = 64,
  parameter int CNT_W     = 16,
  localparam int ID_W     = WORD_W - CODE_W,
  localparam int ADDR_W   = $clog2(LOG_WORDS),
  localparam int PEND_W   = 3 + HW_W,
  localparam int NSRC     = NUM_TERM + 1,
  localparam int IDX_W    = $clog2(NSRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   hw_evt_i,
  input  logic [HW_W-1:0]        hw_cause_i,
  input  logic [ID_W-1:0]        hw_id_i,
  input  logic [NUM_TERM-1:0]    term_evt_i,
  input  logic [NUM_TERM*ID_W-1:0] term_id_i,
  input  logic                   srv_i,
  input  logic                   reg_rd_i,
  input  logic                   reg_addr_i,
  output logic                   log_we_o,
  output logic [ADDR_W-1:0]      log_addr_o,
  output logic [WORD_W-1:0]      log_word0_o,
  output logic [WORD_W-1:0]      log_word1_o,
  output logic [CNT_W-1:0]       evt_cnt_o,
  output logic                   irq_o,
  output logic [PEND_W-1:0]      pend_o,
  output logic [WORD_W-1:0]      reg_rdata_o
);
  logic [NSRC-1:0]      evt, full, grant;
  logic [ID_W-1:0]      id_in [NSRC];
  logic [ID_W-1:0]      id_q  [NSRC];
  logic [IDX_W-1:0]     win;
  logic                 any;
  logic [CNT_W-1:0]     cnt_next;
  logic [WORD_W+CNT_W-1:0] cnt_ext;

  // index 0 is hardware; terminal k sits at k+1, matching its source code
  assign evt   = {term_evt_i, hw_evt_i};
  assign id_in[0] = hw_id_i;

  for (genvar k = 0; k < NUM_TERM; k++) begin : g_tid
    assign id_in[k+1] = term_id_i[k*ID_W +: ID_W];
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    irq_src_latch #(.ID_W(ID_W)) i_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt[s]),
      .id_i   (id_in[s]),
      .grant_i(grant[s]),
      .full_o (full[s]),
      .id_o   (id_q[s])
    );
  end

  irq_arbiter #(.N(NSRC)) i_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (full),
    .grant_o(grant),
    .idx_o  (win),
    .any_o  (any)
  );

  irq_log_ctrl #(.LOG_WORDS(LOG_WORDS), .CNT_W(CNT_W)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (any),
    .srv_i     (srv_i),
    .addr_o    (log_addr_o),
    .cnt_o     (evt_cnt_o),
    .cnt_next_o(cnt_next)
  );

  irq_pend_reg #(.HW_W(HW_W), .CNT_W(CNT_W), .WORD_W(WORD_W)) i_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_evt_i  (hw_evt_i),
    .hw_cause_i(hw_cause_i),
    .term_evt_i(term_evt_i[3:0]),
    .srv_i     (srv_i),
    .rd_i      (reg_rd_i),
    .addr_i    (reg_addr_i),
    .cnt_i     (evt_cnt_o),
    .pend_o    (pend_o),
    .rdata_o   (reg_rdata_o)
  );

  assign cnt_ext     = {{WORD_W{1'b0}}, cnt_next};
  assign log_we_o    = any;
  assign log_word0_o = {id_q[win], CODE_W'(win)};
  assign log_word1_o = cnt_ext[WORD_W-1:0];
  assign irq_o       = (evt_cnt_o != '0);

  // R8
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    log_we_o |=> irq_o);
  // R2
  rec_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    log_we_o |-> (log_word0_o[CODE_W-1:0] < CODE_W'(NSRC)));
endmodule

// File: tb/test_irq_log_top.sv
module test_irq_log_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_evt = 1'b0;
  logic [7:0] hw_cause = '0;
  logic [12:0] hw_id = '0;
  logic [3:0] term_evt = '0;
  logic [51:0] term_id = '0;
  logic srv = 1'b0, rd = 1'b0, raddr = 1'b0;
  logic log_we;
  logic [5:0] log_addr;
  logic [15:0] w0, w1, cnt, rdata;
  logic irq;
  logic [10:0] pend;

  int checks = 0, errors = 0;
  int total = 0, model_cnt = 0, bulk_seen = 0;
  bit sb_en = 1'b1;
  logic [37:0] expq[$];

  always #10 clk = ~clk;

  irq_log_top i_irq_log_top (
    .clk_i(clk), .rst_ni(rst_n), .hw_evt_i(hw_evt), .hw_cause_i(hw_cause),
    .hw_id_i(hw_id), .term_evt_i(term_evt), .term_id_i(term_id), .srv_i(srv),
    .reg_rd_i(rd), .reg_addr_i(raddr), .log_we_o(log_we), .log_addr_o(log_addr),
    .log_word0_o(w0), .log_word1_o(w1), .evt_cnt_o(cnt), .irq_o(irq),
    .pend_o(pend), .reg_rdata_o(rdata)
  );

  task automatic check(string req, logic [37:0] act, logic [37:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected record: count rises by one, saturating at 65535
  task automatic push_exp(int src, logic [12:0] id);
    logic [5:0] a;
    logic [15:0] word0;
    a = 6'((total * 2) % 64);
    if (model_cnt < 65535) model_cnt++;
    word0 = {id, 3'(src)};
    expq.push_back({a, word0, 16'(model_cnt)});
    total++;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // monitor: compare each log write against the scoreboard
  always @(negedge clk) begin
    if (rst_n && log_we) begin
      if (!sb_en) bulk_seen++;
      else if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected write actual=%0h expected=none", {log_addr, w0, w1});
      end else begin
        logic [37:0] e;
        e = expq.pop_front();
        check("R2/R3/R4 record", {log_addr, w0, w1}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R1 reset state
    check("R1 cnt", 38'(cnt), 0);
    check("R1 irq", 38'(irq), 0);
    check("R1 pend", 38'(pend), 0);
    check("R1 we", 38'(log_we), 0);
    check("R1 addr", 38'(log_addr), 0);
    step(); rst_n = 1'b1; step();

    // single bus controller event
    term_evt = 4'b0001; term_id[12:0] = 13'h123; push_exp(1, 13'h123);
    step(); term_evt = '0;
    step(); step(); #4;
    check("R6 cnt single", 38'(cnt), 1);
    check("R8 irq high", 38'(irq), 1);
    check("R9 pend bc", 38'(pend[2:0]), 3'b001);

    // service
    srv = 1'b1; model_cnt = 0; step(); srv = 1'b0; #4;
    check("R7 cnt cleared", 38'(cnt), 0);
    check("R8 irq low", 38'(irq), 0);
    check("R9 pend cleared", 38'(pend[2:0]), 0);

    // all five sources at once
    hw_evt = 1'b1; hw_cause = 8'h05; hw_id = 13'h0aa; term_evt = 4'b1111;
    for (int k = 0; k < 4; k++) term_id[k*13 +: 13] = 13'(16'h100 + k);
    push_exp(0, 13'h0aa);
    for (int k = 0; k < 4; k++) push_exp(k + 1, 13'(16'h100 + k));
    step(); hw_evt = 1'b0; hw_cause = '0; term_evt = '0;
    repeat (6) step(); #4;
    check("R4 cnt after burst", 38'(cnt), 5);
    check("R9 pend terms", 38'(pend[2:0]), 3'b111);
    check("R10 pend hw", 38'(pend[10:3]), 8'h05);

    // register reads
    rd = 1'b1; raddr = 1'b0; step(); rd = 1'b0; #4;
    check("R10 read pend", 38'(rdata), 38'({8'h05, 3'b111}));
    check("R10 hw cleared", 38'(pend[10:3]), 0);
    check("R10 terms kept", 38'(pend[2:0]), 3'b111);
    rd = 1'b1; raddr = 1'b1; step(); rd = 1'b0; #4;
    check("R10 read cnt", 38'(rdata), 5);

    // R5: second bc pulse while first is held behind hardware
    hw_evt = 1'b1; hw_id = 13'h011; term_evt = 4'b0001; term_id[12:0] = 13'h222;
    push_exp(0, 13'h011); push_exp(1, 13'h222);
    step(); hw_evt = 1'b0; term_id[12:0] = 13'h333;
    step(); term_evt = '0;
    repeat (4) step(); #4;
    check("R5 cnt after drop", 38'(cnt), 7);

    // R7: service in the cycle a record is written
    term_evt = 4'b0010; term_id[25:13] = 13'h044;
    step(); term_evt = '0; srv = 1'b1; model_cnt = 0; push_exp(2, 13'h044);
    step(); srv = 1'b0; #4;
    check("R7 cnt with concurrent write", 38'(cnt), 1);

    // R3: wrap of the write address over 40 records
    for (int n = 0; n < 40; n++) begin
      term_evt = 4'b1000; term_id[51:39] = 13'(n);
      push_exp(4, 13'(n));
      step();
    end
    term_evt = '0;
    repeat (3) step(); #4;
    check("R3 addr after wrap", 38'(log_addr), 38'((total * 2) % 64));

    // R6: saturation with a long back-to-back train
    sb_en = 1'b0;
    term_evt = 4'b0001;
    repeat (65600) step();
    term_evt = '0;
    repeat (3) step(); #4;
    check("R6 bulk records", 38'(bulk_seen), 65600);
    check("R6 saturated cnt", 38'(cnt), 65535);
    total += bulk_seen; model_cnt = 65535;
    sb_en = 1'b1;
    term_evt = 4'b0001; term_id[12:0] = 13'h0ff; push_exp(1, 13'h0ff);
    step(); term_evt = '0;
    repeat (3) step(); #4;
    check("R6 still saturated", 38'(cnt), 65535);
    check("R2 queue drained", 38'(expq.size()), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule